// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one indivisible memory update on behalf of a processor. It sits beside the processor's cache line or memory word and supports three operations. Compare-and-swap stores a new value only when the current contents match an expected value. Test-and-set stores a fixed set value. Fetch-and-increment stores the current value plus one. Every operation returns the value the location held before the update.

The unit reads the word and writes it back while it holds the line exclusively, so no other agent can touch the line between the read and the write. When the line is already dirty and owned locally (Modified), the unit goes straight to the read and sends nothing toward the coherence layer. Otherwise it raises an ownership request and waits for the grant before it reads. From the moment ownership is held until the write cycle, snoops that hit the same line are held off. Only one operation is in flight at a time: a busy flag turns away new requests until the response has been returned.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Compare-and-swap (op code 2'b00) with current contents equal to `req_cmp` writes `req_new` to the address and returns the previous contents on `rsp_old`.
- R2: Compare-and-swap whose compare value differs from the current contents performs no write (`wr_en` stays low) and still returns the current contents.
- R3: Test-and-set (op code 2'b01) writes the parameter `SET_VAL` (default 1) and returns the previous contents.
- R4: Fetch-and-increment (op code 2'b10) returns the previous contents and writes that value plus one, wrapping modulo 2^DW (all-ones becomes zero).
- R5: When `line_modified` is high at acceptance, `own_req` is never raised, `rd_en` is high in the cycle after acceptance, and `rsp_valid` follows one cycle later.
- R6: When `line_modified` is low at acceptance, `own_req` rises in the next cycle and is held until `own_gnt` is seen. `rd_en` is never high while `own_req` is high. The read comes in the cycle after the grant, and the response one cycle after the read.
- R7: `wr_en` is high only in the cycle in which `rsp_valid` is high, and `wr_addr` then equals the accepted address.
- R8: `snp_stall` is high exactly when `snp_valid` is high, `snp_addr` equals the address of the operation in progress, and ownership is held (the read cycle and the response cycle). It is low during the ownership wait, when idle, and for other addresses.
- R9: `busy` is high from the cycle after acceptance through the response cycle. A request presented while `busy` is high is ignored: it produces no response and no write.
- R10: After reset, `busy`, `own_req`, `rd_en`, `wr_en`, `rsp_valid` and `snp_stall` are low.
- R11: A request carrying the reserved op code 2'b11 is not accepted: `busy` stays low and no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | Operation code: 00 compare-and-swap, 01 test-and-set, 10 fetch-and-increment, 11 reserved |
| req_addr | input | AW | Target word address |
| req_cmp | input | DW | Expected value for compare-and-swap |
| req_new | input | DW | Replacement value for compare-and-swap |
| busy | output | 1 | Operation in progress; requests are refused |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_old | output | DW | Contents before the update |
| line_modified | input | 1 | Target line is already held locally in Modified state |
| own_req | output | 1 | Exclusive ownership request toward the coherence layer |
| own_gnt | input | 1 | Exclusive ownership granted |
| rd_en | output | 1 | Line read strobe |
| rd_addr | output | AW | Line read address |
| rd_data | input | DW | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Line write strobe |
| wr_addr | output | AW | Line write address |
| wr_data | output | DW | Line write data |
| snp_valid | input | 1 | Incoming snoop or invalidate |
| snp_addr | input | AW | Snoop address |
| snp_stall | output | 1 | Snoop must wait |

## Verification
The assertions rely on the storage returning read data exactly one cycle after `rd_en`. They also rely on `own_gnt` being driven only while `own_req` is high. The bench's memory model and its grant model are built to keep both promises: the grant rises a fixed number of cycles into a request and drops with it. Snoops are presented only as level inputs that are never acknowledged. Requests are started only when `busy` is low, except in the one directed case that tests refusal while busy.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [1:0] {
    OP_CAS = 2'b00,
    OP_TAS = 2'b01,
    OP_INC = 2'b10,
    OP_RSV = 2'b11
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_OWN  = 2'b01,
    ST_READ = 2'b10,
    ST_EXEC = 2'b11
  } amo_state_e;

endpackage

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl
  import atomic_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       line_modified,
  input  logic       own_gnt,
  output logic       accept,
  output logic       busy,
  output logic       own_req,
  output logic       rd_en,
  output logic       exec,
  output logic       held
);

  amo_state_e state_q, state_d;

  assign accept  = (state_q == ST_IDLE) && req_valid && (req_op != OP_RSV);
  assign busy    = (state_q != ST_IDLE);
  assign own_req = (state_q == ST_OWN);
  assign rd_en   = (state_q == ST_READ);
  assign exec    = (state_q == ST_EXEC);
  assign held    = rd_en || exec;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = line_modified ? ST_READ : ST_OWN;
      ST_OWN:  if (own_gnt) state_d = ST_READ;
      ST_READ: state_d = ST_EXEC;
      ST_EXEC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] SET_VAL = 1
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] cmp_val,
  input  logic [DW-1:0] new_val,
  output logic          wr_need,
  output logic [DW-1:0] wr_val
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    wr_need = 1'b0;
    wr_val  = old_val;
    unique case (amo_op_e'(op))
      OP_CAS: begin
        wr_need = (old_val == cmp_val);
        wr_val  = new_val;
      end
      OP_TAS: begin
        wr_need = 1'b1;
        wr_val  = SET_VAL;
      end
      OP_INC: begin
        wr_need = 1'b1;
        wr_val  = old_val + ONE;
      end
      default: begin
        wr_need = 1'b0;
        wr_val  = old_val;
      end
    endcase
  end

endmodule

// File: rtl/atomic_rmw_snoop.sv
module atomic_rmw_snoop #(
  parameter int AW = 32
) (
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic [AW-1:0] line_addr,
  input  logic          held,
  output logic          stall
);

  assign stall = snp_valid && held && (snp_addr == line_addr);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int            DW      = 32,
  parameter int            AW      = 32,
  parameter logic [DW-1:0] SET_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_cmp,
  input  logic [DW-1:0] req_new,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_old,
  input  logic          line_modified,
  output logic          own_req,
  input  logic          own_gnt,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_stall
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic          accept, exec, held, wr_need;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] cmp_q, new_q, wr_val;

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      cmp_q  <= req_cmp;
      new_q  <= req_new;
    end
  end

  atomic_rmw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .line_modified (line_modified),
    .own_gnt       (own_gnt),
    .accept        (accept),
    .busy          (busy),
    .own_req       (own_req),
    .rd_en         (rd_en),
    .exec          (exec),
    .held          (held)
  );

  atomic_rmw_alu #(.DW(DW), .SET_VAL(SET_VAL)) u_alu (
    .op      (op_q),
    .old_val (rd_data),
    .cmp_val (cmp_q),
    .new_val (new_q),
    .wr_need (wr_need),
    .wr_val  (wr_val)
  );

  atomic_rmw_snoop #(.AW(AW)) u_snoop (
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .line_addr (addr_q),
    .held      (held),
    .stall     (snp_stall)
  );

  assign rsp_valid = exec;
  assign rsp_old   = rd_data;
  assign rd_addr   = addr_q;
  assign wr_addr   = addr_q;
  assign wr_en     = exec && wr_need;
  assign wr_data   = wr_val;

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic          busy,
  input logic          rsp_valid,
  input logic          line_modified,
  input logic          own_req,
  input logic          own_gnt,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] wr_addr,
  input logic          snp_stall
);

  logic acc;
  assign acc = req_valid && !busy && (req_op != 2'b11);

  assert_write_in_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rsp_valid && (wr_addr == rd_addr));

  assert_local_no_traffic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && line_modified |=> !own_req && rd_en);

  assert_remote_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !line_modified |=> own_req);

  assert_hold_until_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    own_req && !own_gnt |=> own_req);

  assert_no_read_unowned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    own_req |-> !rd_en);

  assert_read_then_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  assert_idle_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);

  assert_stall_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_stall |-> busy && !own_req);

  assert_reserved_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_op == 2'b11 |=> !busy);

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.AW(AW)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .busy          (busy),
  .rsp_valid     (rsp_valid),
  .line_modified (line_modified),
  .own_req       (own_req),
  .own_gnt       (own_gnt),
  .rd_en         (rd_en),
  .wr_en         (wr_en),
  .rd_addr       (rd_addr),
  .wr_addr       (wr_addr),
  .snp_stall     (snp_stall)
);

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int GNT_DLY = 2;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] init;
    logic [DW-1:0] cmp;
    logic [DW-1:0] nv;
    logic          mdf;
    logic [DW-1:0] exp_mem;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 4'd1, 32'd5,          32'd5, 32'd9,         1'b1, 32'd9},
    '{2'b00, 4'd2, 32'd5,          32'd6, 32'd9,         1'b0, 32'd5},
    '{2'b01, 4'd3, 32'd0,          32'd0, 32'd0,         1'b1, 32'd1},
    '{2'b01, 4'd4, 32'd1,          32'd0, 32'd0,         1'b0, 32'd1},
    '{2'b10, 4'd5, 32'd7,          32'd0, 32'd0,         1'b1, 32'd8},
    '{2'b10, 4'd6, 32'hFFFF_FFFF,  32'd0, 32'd0,         1'b0, 32'd0},
    '{2'b00, 4'd7, 32'd0,          32'd0, 32'h0000_DEAD, 1'b0, 32'h0000_DEAD},
    '{2'b10, 4'd8, 32'h7FFF_FFFF,  32'd0, 32'd0,         1'b1, 32'h8000_0000}
  };

  logic clk, rst_n;
  logic req_valid, line_modified, own_gnt, snp_valid;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr, snp_addr, rd_addr, wr_addr;
  logic [DW-1:0] req_cmp, req_new, rd_data, wr_data, rsp_old;
  logic busy, rsp_valid, own_req, rd_en, wr_en, snp_stall;

  logic [DW-1:0] mem [16];
  int n_chk, n_bad, own_cnt;
  bit done;

  atomic_rmw_unit #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_old(rsp_old), .line_modified(line_modified),
    .own_req(own_req), .own_gnt(own_gnt), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_stall(snp_stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always @(negedge clk) begin
    if (own_req) own_cnt = own_cnt + 1;
    else         own_cnt = 0;
    own_gnt = own_req && (own_cnt > GNT_DLY);
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input vec_t v);
    if (v.op == 2'b01) return "R3";
    if (v.op == 2'b10) return "R4";
    return (v.init == v.cmp) ? "R1" : "R2";
  endfunction

  task automatic run_vec(input vec_t v);
    int lat, exp_lat, wr_seen;
    bit own_ok, stall_ok, wr_ok, busy_ok;
    logic [DW-1:0] old;
    mem[v.addr] = v.init;
    exp_lat = v.mdf ? 2 : 3 + GNT_DLY;
    lat = 0; own_ok = 1; stall_ok = 1; wr_ok = 1; busy_ok = 1; wr_seen = 0; old = '0;
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr;
    req_cmp = v.cmp; req_new = v.nv; line_modified = v.mdf;
    snp_valid = 1'b1; snp_addr = v.addr;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (!busy) busy_ok = 0;
      if (v.mdf && own_req) own_ok = 0;
      if (!v.mdf && k == 1 && !own_req) own_ok = 0;
      if (own_req && rd_en) own_ok = 0;
      if (snp_stall != (k >= exp_lat - 1)) stall_ok = 0;
      if (wr_en) begin
        wr_seen++;
        if (!rsp_valid || wr_addr != v.addr) wr_ok = 0;
      end
      if (rsp_valid) begin
        lat = k; old = rsp_old;
        break;
      end
    end
    snp_valid = 1'b0;
    @(negedge clk);
    if (busy || rsp_valid) busy_ok = 0;
    chk(old == v.init, {op_tag(v), " old value"}, old, v.init);
    chk(mem[v.addr] == v.exp_mem, {op_tag(v), " stored value"}, mem[v.addr], v.exp_mem);
    chk(lat == exp_lat, v.mdf ? "R5 latency" : "R6 latency", lat, exp_lat);
    chk(own_ok, v.mdf ? "R5 ownership" : "R6 ownership", own_ok, 1);
    chk(stall_ok, "R8 snoop stall window", stall_ok, 1);
    chk(wr_ok && (wr_seen == (v.init == v.exp_mem && v.op == 2'b00 ? 0 : 1)),
        "R7 write strobe", wr_seen, 1);
    chk(busy_ok, "R9 busy window", busy_ok, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; own_cnt = 0; own_gnt = 0;
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_cmp = 0; req_new = 0;
    line_modified = 0; snp_valid = 0; snp_addr = 0; rd_data = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, own_req, rd_en, wr_en, rsp_valid, snp_stall} == 6'b0,
        "R10 reset outputs", {busy, own_req, rd_en, wr_en, rsp_valid, snp_stall}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !rsp_valid, "R10 idle after release", busy, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R9: request during busy is ignored
    mem[9] = 32'd10; mem[10] = 32'd44;
    req_valid = 1; req_op = 2'b10; req_addr = 4'd9; line_modified = 1;
    @(negedge clk);
    req_op = 2'b01; req_addr = 4'd10;
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!busy, "R9 busy dropped after response", busy, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!rsp_valid && !busy, "R9 no second response", rsp_valid, 0);
    end
    chk(mem[10] == 32'd44, "R9 ignored request wrote nothing", mem[10], 32'd44);
    chk(mem[9] == 32'd11, "R4 increment beside ignored request", mem[9], 32'd11);

    // R11 reserved op
    req_valid = 1; req_op = 2'b11; req_addr = 4'd11; mem[11] = 32'd3;
    @(negedge clk);
    req_valid = 0;
    chk(!busy, "R11 reserved op not accepted", busy, 0);
    @(negedge clk);
    chk(!rsp_valid && mem[11] == 32'd3, "R11 no response", rsp_valid, 0);

    // R8: other address not stalled, idle not stalled
    snp_valid = 1; snp_addr = 4'd12;
    chk(!snp_stall, "R8 idle no stall", snp_stall, 0);
    req_valid = 1; req_op = 2'b01; req_addr = 4'd13; line_modified = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!snp_stall && rd_en, "R8 other address not stalled", snp_stall, 0);
    @(negedge clk);
    chk(!snp_stall && rsp_valid, "R8 other address in response cycle", snp_stall, 0);
    snp_valid = 0;
    @(negedge clk);

    // R2 with line not modified: compare fails, no write
    mem[14] = 32'hAAAA_0000;
    req_valid = 1; req_op = 2'b00; req_addr = 4'd14; req_cmp = 32'hAAAA_0001;
    req_new = 32'd1; line_modified = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      req_valid = 0;
      if (wr_en) chk(0, "R2 unexpected write", 1, 0);
    end
    chk(mem[14] == 32'hAAAA_0000, "R2 contents kept", mem[14], 32'hAAAA_0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule